// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central hazard-tracking control for a machine with four multicycle, non-pipelined functional units. Decoded instructions arrive one at a time, in program order, each naming a target unit, a destination register and two source registers. The controller admits an instruction only when its unit is idle and no earlier instruction still owns the same destination. After that, each instruction moves through the remaining steps at its own pace. It reads its operands once every producer it depends on has written. It executes for a fixed, per-unit number of cycles. It writes its result once no earlier instruction still needs the old register value.

Per unit, the controller keeps one status slot: phase, destination, sources, the producing unit for each source and a ready flag for each source. A register-owner table records, for each register, which unit will write it next. Grants go to the units when they may read and when they may write. A stall goes back to the front end whenever the presented instruction cannot be admitted. Unit arithmetic is modelled by latency counters. Fetch, decode and the register file lie outside the block.

Top module: `scoreboard_ctrl`

## Requirements
- R1: Unit codes are 0 integer, 1 multiplier, 2 adder and 3 divider. `stall_o` is high exactly when `iss_valid_i` is high and the addressed unit is busy or the destination is still owned (see R2). A unit is free for a new instruction from the cycle after its write grant.
- R2: An instruction whose destination is still owned by an earlier instruction stalls until the cycle after that instruction's write grant.
- R3: An instruction admitted in cycle n whose sources have no pending producer gets its read grant in cycle n+1.
- R4: A source owned by an earlier instruction becomes ready in the cycle after that producer's write grant. The read grant comes in that cycle if the other source is also ready.
- R5: Execution takes the unit's latency L (1, 10, 2 and 40 cycles by default for units 0 to 3). With no hold, the write grant comes in cycle r+L+1 when the read grant came in cycle r.
- R6: A write is held while an earlier instruction that has not yet left its read step holds a ready copy of the destination register as a source. The write grant comes in the cycle after that reader's read grant.
- R7: Admission is in order, but a later independent instruction may read and write before an earlier one that is waiting on data.
- R8: `busy_o[u]` is high from the cycle after admission through the write-grant cycle. During a write grant, `wr_dst_o[u*RW +: RW]` shows that instruction's destination.
- R9: While `rst_ni` is low, and after it is released with no instruction, all grants, busy flags and `stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | An instruction is presented for admission |
| iss_fu_i | input | 2 | Target unit code |
| iss_dst_i | input | RW | Destination register |
| iss_src_a_i | input | RW | First source register |
| iss_src_b_i | input | RW | Second source register |
| stall_o | output | 1 | Presented instruction is not admitted this cycle |
| busy_o | output | 4 | Per-unit busy flag |
| rd_gnt_o | output | 4 | Per-unit operand read grant |
| wr_gnt_o | output | 4 | Per-unit result write grant |
| wr_dst_o | output | 4*RW | Per-unit destination register, unit u at bits u*RW |

## Verification
The bench uses 32 registers and latencies of 1, 6, 2 and 9 cycles for the integer, multiplier, adder and divider units. With these short multiplier and divider windows, every conflict resolves within a few tens of cycles: a write-after-write stall of eleven cycles, a read-after-write wait behind the multiplier, and a write-after-read hold where a one-cycle integer result must wait for an adder still blocked on the multiplier. Every expected grant cycle follows from these latencies and the timing rules above.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU = 4;
  localparam int FU_W   = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_EXEC = 2'd2,
    PH_WB   = 2'd3
  } phase_e;
endpackage

// File: rtl/sb_result_tbl.sv
module sb_result_tbl
  import sb_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [RW-1:0]        set_reg_i,
  input  logic [FU_W-1:0]      set_fu_i,
  input  logic [NUM_FU-1:0]    clr_i,
  input  logic [NUM_FU*RW-1:0] clr_reg_i,
  input  logic [RW-1:0]        look_a_i,
  input  logic [RW-1:0]        look_b_i,
  input  logic [RW-1:0]        look_d_i,
  output logic                 pend_a_o,
  output logic                 pend_b_o,
  output logic [FU_W-1:0]      prod_a_o,
  output logic [FU_W-1:0]      prod_b_o,
  output logic                 pend_d_o
);
  logic [NREG-1:0] vld_q;
  logic [FU_W-1:0] fu_q [NREG];
  logic [NREG-1:0] clr_vec, set_vec;

  always_comb begin
    clr_vec = '0;
    for (int u = 0; u < NUM_FU; u++)
      if (clr_i[u]) clr_vec[clr_reg_i[u*RW +: RW]] = 1'b1;
    set_vec = '0;
    if (set_i) set_vec[set_reg_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int r = 0; r < NREG; r++) fu_q[r] <= '0;
    end else begin
      vld_q <= (vld_q & ~clr_vec) | set_vec;
      if (set_i) fu_q[set_reg_i] <= set_fu_i;
    end
  end

  // a producer writing this very cycle counts as already done
  assign prod_a_o = fu_q[look_a_i];
  assign prod_b_o = fu_q[look_b_i];
  assign pend_a_o = vld_q[look_a_i] && !clr_i[fu_q[look_a_i]];
  assign pend_b_o = vld_q[look_b_i] && !clr_i[fu_q[look_b_i]];
  assign pend_d_o = vld_q[look_d_i];
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
  import sb_pkg::*;
#(
  parameter int RW  = 5,
  parameter int LAT = 1,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [RW-1:0]     dst_i,
  input  logic [RW-1:0]     src_a_i,
  input  logic [RW-1:0]     src_b_i,
  input  logic              pend_a_i,
  input  logic              pend_b_i,
  input  logic [FU_W-1:0]   prod_a_i,
  input  logic [FU_W-1:0]   prod_b_i,
  input  logic [NUM_FU-1:0] wr_all_i,
  input  logic              war_hold_i,
  output logic              busy_o,
  output logic              waiting_o,
  output logic              rd_gnt_o,
  output logic              wr_gnt_o,
  output logic [RW-1:0]     dst_o,
  output logic [RW-1:0]     src_a_o,
  output logic [RW-1:0]     src_b_o,
  output logic              rdy_a_o,
  output logic              rdy_b_o
);
  phase_e          phase_q;
  logic [RW-1:0]   dst_q, sa_q, sb_q;
  logic [FU_W-1:0] pa_q, pb_q;
  logic            ra_q, rb_q;
  logic [CW-1:0]   cnt_q;

  assign busy_o    = (phase_q != PH_IDLE);
  assign waiting_o = (phase_q == PH_WAIT);
  assign rd_gnt_o  = waiting_o && ra_q && rb_q;
  assign wr_gnt_o  = (phase_q == PH_WB) && !war_hold_i;
  assign dst_o     = dst_q;
  assign src_a_o   = sa_q;
  assign src_b_o   = sb_q;
  assign rdy_a_o   = ra_q;
  assign rdy_b_o   = rb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      dst_q   <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      pa_q    <= '0;
      pb_q    <= '0;
      ra_q    <= 1'b0;
      rb_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (issue_i) begin
          phase_q <= PH_WAIT;
          dst_q   <= dst_i;
          sa_q    <= src_a_i;
          sb_q    <= src_b_i;
          pa_q    <= prod_a_i;
          pb_q    <= prod_b_i;
          ra_q    <= !pend_a_i;
          rb_q    <= !pend_b_i;
        end
        PH_WAIT: begin
          if (rd_gnt_o) begin
            phase_q <= PH_EXEC;
            cnt_q   <= CW'(LAT);
          end else begin
            if (!ra_q && wr_all_i[pa_q]) ra_q <= 1'b1;
            if (!rb_q && wr_all_i[pb_q]) rb_q <= 1'b1;
          end
        end
        PH_EXEC: begin
          if (cnt_q == CW'(1)) phase_q <= PH_WB;
          else                 cnt_q   <= cnt_q - CW'(1);
        end
        PH_WB: if (wr_gnt_o) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
  import sb_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40,
  localparam int RW     = $clog2(NREG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 iss_valid_i,
  input  logic [FU_W-1:0]      iss_fu_i,
  input  logic [RW-1:0]        iss_dst_i,
  input  logic [RW-1:0]        iss_src_a_i,
  input  logic [RW-1:0]        iss_src_b_i,
  output logic                 stall_o,
  output logic [NUM_FU-1:0]    busy_o,
  output logic [NUM_FU-1:0]    rd_gnt_o,
  output logic [NUM_FU-1:0]    wr_gnt_o,
  output logic [NUM_FU*RW-1:0] wr_dst_o
);
  logic [NUM_FU-1:0] busy, waiting, rd_gnt, wr_gnt, war_hold, issue_en;
  logic [NUM_FU-1:0] rdy_a, rdy_b;
  logic [RW-1:0]     dst_v [NUM_FU];
  logic [RW-1:0]     sa_v  [NUM_FU];
  logic [RW-1:0]     sb_v  [NUM_FU];
  logic              pend_a, pend_b, pend_d, iss_ok, iss_fire;
  logic [FU_W-1:0]   prod_a, prod_b;

  // structural and write-after-write checks at admission
  assign iss_ok   = !busy[iss_fu_i] && !pend_d;
  assign iss_fire = iss_valid_i && iss_ok;
  assign stall_o  = iss_valid_i && !iss_ok;

  sb_result_tbl #(.NREG(NREG)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (iss_fire),
    .set_reg_i (iss_dst_i),
    .set_fu_i  (iss_fu_i),
    .clr_i     (wr_gnt),
    .clr_reg_i (wr_dst_o),
    .look_a_i  (iss_src_a_i),
    .look_b_i  (iss_src_b_i),
    .look_d_i  (iss_dst_i),
    .pend_a_o  (pend_a),
    .pend_b_o  (pend_b),
    .prod_a_o  (prod_a),
    .prod_b_o  (prod_b),
    .pend_d_o  (pend_d)
  );

  // write-after-read: a waiting reader holding a ready old copy blocks the write
  always_comb begin
    war_hold = '0;
    for (int i = 0; i < NUM_FU; i++)
      for (int j = 0; j < NUM_FU; j++)
        if (i != j && waiting[j] &&
            ((sa_v[j] == dst_v[i] && rdy_a[j]) || (sb_v[j] == dst_v[i] && rdy_b[j])))
          war_hold[i] = 1'b1;
  end

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    localparam int L = (g == 0) ? LAT_INT : (g == 1) ? LAT_MUL :
                       (g == 2) ? LAT_ADD : LAT_DIV;

    assign issue_en[g] = iss_fire && (iss_fu_i == FU_W'(g));

    sb_fu_slot #(.RW(RW), .LAT(L)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .issue_i    (issue_en[g]),
      .dst_i      (iss_dst_i),
      .src_a_i    (iss_src_a_i),
      .src_b_i    (iss_src_b_i),
      .pend_a_i   (pend_a),
      .pend_b_i   (pend_b),
      .prod_a_i   (prod_a),
      .prod_b_i   (prod_b),
      .wr_all_i   (wr_gnt),
      .war_hold_i (war_hold[g]),
      .busy_o     (busy[g]),
      .waiting_o  (waiting[g]),
      .rd_gnt_o   (rd_gnt[g]),
      .wr_gnt_o   (wr_gnt[g]),
      .dst_o      (dst_v[g]),
      .src_a_o    (sa_v[g]),
      .src_b_o    (sb_v[g]),
      .rdy_a_o    (rdy_a[g]),
      .rdy_b_o    (rdy_b[g])
    );

    assign wr_dst_o[g*RW +: RW] = dst_v[g];
  end

  assign busy_o   = busy;
  assign rd_gnt_o = rd_gnt;
  assign wr_gnt_o = wr_gnt;
endmodule

// File: rtl/scoreboard_ctrl_chk.sv
module scoreboard_ctrl_chk
  import sb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              iss_valid_i,
  input logic [FU_W-1:0]   iss_fu_i,
  input logic              stall_o,
  input logic [NUM_FU-1:0] busy_o,
  input logic [NUM_FU-1:0] rd_gnt_o,
  input logic [NUM_FU-1:0] wr_gnt_o
);
  assert_stall_needs_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iss_valid_i |-> !stall_o);

  assert_reset_quiet_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (busy_o == '0 && rd_gnt_o == '0 && wr_gnt_o == '0));

  for (genvar u = 0; u < NUM_FU; u++) begin : g_u
    assert_busy_stall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss_valid_i && iss_fu_i == FU_W'(u) && busy_o[u]) |-> stall_o);

    assert_issue_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss_valid_i && !stall_o && iss_fu_i == FU_W'(u)) |=> busy_o[u]);

    assert_grant_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_gnt_o[u] || wr_gnt_o[u]) |-> busy_o[u]);

    assert_free_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_gnt_o[u] |=> !busy_o[u]);

    assert_exec_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_gnt_o[u] |=> (!wr_gnt_o[u] && !rd_gnt_o[u]));
  end
endmodule

bind scoreboard_ctrl scoreboard_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_valid_i (iss_valid_i),
  .iss_fu_i    (iss_fu_i),
  .stall_o     (stall_o),
  .busy_o      (busy_o),
  .rd_gnt_o    (rd_gnt_o),
  .wr_gnt_o    (wr_gnt_o)
);

// File: tb/scoreboard_ctrl_bench.sv
`timescale 1ns/1ps
module scoreboard_ctrl_bench;
  localparam int NREG = 32;
  localparam int RW   = 5;
  localparam int LI = 1, LM = 6, LA = 2, LD = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          iss_valid;
  logic [1:0]    iss_fu;
  logic [RW-1:0] iss_dst, iss_a, iss_b;
  logic          stall;
  logic [3:0]    busy, rd_gnt, wr_gnt;
  logic [4*RW-1:0] wr_dst;

  scoreboard_ctrl #(.NREG(NREG), .LAT_INT(LI), .LAT_MUL(LM), .LAT_ADD(LA), .LAT_DIV(LD))
  u_scoreboard_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .iss_valid_i(iss_valid), .iss_fu_i(iss_fu),
    .iss_dst_i(iss_dst), .iss_src_a_i(iss_a), .iss_src_b_i(iss_b),
    .stall_o(stall), .busy_o(busy), .rd_gnt_o(rd_gnt), .wr_gnt_o(wr_gnt), .wr_dst_o(wr_dst)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { int cyc; bit wr; int fu; int dst; int req; } exp_t;
  exp_t expq[$];

  task automatic push(int c, bit w, int f, int d, int r);
    exp_t e;
    e.cyc = c; e.wr = w; e.fu = f; e.dst = d; e.req = r;
    expq.push_back(e);
  endtask

  task automatic check(bit ok, int r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic match(bit w, int u, int d);
    int idx = -1;
    foreach (expq[i])
      if (idx < 0 && expq[i].wr == w && expq[i].fu == u && expq[i].cyc == cyc) idx = i;
    if (idx < 0) begin
      checks++; fails++;
      $display("FAIL R5 unexpected %s grant unit %0d cycle %0d: actual 1 expected 0",
               w ? "write" : "read", u, cyc);
    end else begin
      check(!w || expq[idx].dst == d, expq[idx].req, "grant timing/destination", d, expq[idx].dst);
      expq.delete(idx);
    end
  endtask

  // monitor: pops expected grants as the design raises them
  always @(negedge clk) begin
    if (rst_n && !done)
      for (int u = 0; u < 4; u++) begin
        if (rd_gnt[u]) match(1'b0, u, 0);
        if (wr_gnt[u]) match(1'b1, u, int'(wr_dst[u*RW +: RW]));
      end
  end

  task automatic drain();
    for (int k = 0; k < 80 && expq.size() > 0; k++) @(negedge clk);
    foreach (expq[i]) begin
      checks++; fails++;
      $display("FAIL R%0d missing %s grant unit %0d at cycle %0d: actual 0 expected 1",
               expq[i].req, expq[i].wr ? "write" : "read", expq[i].fu, expq[i].cyc);
    end
    expq.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic at_cycle(int t);
    @(negedge clk);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_issue(int u, int d, int a, int b, output int n, output int st);
    @(negedge clk);
    iss_valid = 1'b1; iss_fu = 2'(u); iss_dst = RW'(d); iss_a = RW'(a); iss_b = RW'(b);
    st = 0;
    #1;
    while (stall) begin
      st++;
      @(negedge clk);
      #1;
    end
    n = cyc;
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  initial begin
    int n, n2, n3, n4, s;
    iss_valid = 1'b0; iss_fu = '0; iss_dst = '0; iss_a = '0; iss_b = '0;
    repeat (3) @(negedge clk);
    // R9 during reset
    check(busy == 4'b0, 9, "busy in reset", int'(busy), 0);
    check((rd_gnt | wr_gnt) == 4'b0, 9, "grants in reset", int'(rd_gnt | wr_gnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(stall == 1'b0, 9, "stall after reset", int'(stall), 0);
    check(busy == 4'b0, 9, "busy after reset", int'(busy), 0);

    // S1: independent instructions, one per unit (R3, R5, R8)
    do_issue(0, 1, 2, 3, n, s);
    push(n + 1, 1'b0, 0, 0, 3);
    push(n + LI + 2, 1'b1, 0, 1, 5);
    at_cycle(n + 3);
    check(busy[0] == 1'b1, 8, "integer busy in write cycle", int'(busy[0]), 1);
    at_cycle(n + 4);
    check(busy[0] == 1'b0, 8, "integer busy after write", int'(busy[0]), 0);
    do_issue(2, 4, 5, 6, n, s);
    push(n + 1, 1'b0, 2, 0, 3);
    push(n + LA + 2, 1'b1, 2, 4, 5);
    do_issue(1, 7, 8, 9, n2, s);
    push(n2 + 1, 1'b0, 1, 0, 3);
    push(n2 + LM + 2, 1'b1, 1, 7, 5);
    do_issue(3, 10, 11, 12, n3, s);
    push(n3 + 1, 1'b0, 3, 0, 3);
    push(n3 + LD + 2, 1'b1, 3, 10, 8);
    check(n3 == n + 2, 1, "back-to-back admission", n3 - n, 2);
    drain();

    // S2: read-after-write wait and overtaking (R4, R7)
    do_issue(1, 13, 14, 15, n, s);
    push(n + 1, 1'b0, 1, 0, 3);
    push(n + LM + 2, 1'b1, 1, 13, 5);
    do_issue(2, 16, 13, 17, n2, s);
    check(n2 == n + 1, 7, "dependent admitted without stall", n2 - n, 1);
    push(n + LM + 3, 1'b0, 2, 0, 4);
    push(n + LM + 3 + LA + 1, 1'b1, 2, 16, 4);
    do_issue(0, 18, 19, 20, n3, s);
    push(n3 + 1, 1'b0, 0, 0, 7);
    push(n3 + LI + 2, 1'b1, 0, 18, 7);
    drain();

    // S3: structural stall on a busy adder (R1)
    do_issue(2, 21, 22, 23, n, s);
    push(n + 1, 1'b0, 2, 0, 3);
    push(n + LA + 2, 1'b1, 2, 21, 5);
    do_issue(2, 24, 25, 26, n2, s);
    check(n2 == n + LA + 3, 1, "admission cycle after busy unit", n2 - n, LA + 3);
    check(s == LA + 2, 1, "structural stall cycles", s, LA + 2);
    push(n2 + 1, 1'b0, 2, 0, 1);
    push(n2 + LA + 2, 1'b1, 2, 24, 1);
    drain();

    // S4: write-after-write stall (R2)
    do_issue(3, 27, 28, 29, n, s);
    push(n + 1, 1'b0, 3, 0, 3);
    push(n + LD + 2, 1'b1, 3, 27, 5);
    do_issue(0, 27, 30, 31, n2, s);
    check(n2 == n + LD + 3, 2, "admission after owner writes", n2 - n, LD + 3);
    check(s == LD + 2, 2, "write-after-write stall cycles", s, LD + 2);
    push(n2 + 1, 1'b0, 0, 0, 2);
    push(n2 + LI + 2, 1'b1, 0, 27, 2);
    drain();

    // S5: write-after-read hold (R6)
    do_issue(1, 2, 3, 4, n, s);
    push(n + 1, 1'b0, 1, 0, 3);
    push(n + LM + 2, 1'b1, 1, 2, 5);
    do_issue(2, 5, 2, 6, n2, s);
    push(n + LM + 3, 1'b0, 2, 0, 4);
    push(n + LM + 3 + LA + 1, 1'b1, 2, 5, 5);
    do_issue(0, 6, 7, 8, n4, s);
    check(n4 == n + 2, 7, "independent admission", n4 - n, 2);
    push(n4 + 1, 1'b0, 0, 0, 7);
    push(n + LM + 4, 1'b1, 0, 6, 6);   // R6: held until the adder has read r6
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule